// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block is the configuration front end of a peripheral controller on a byte-wide I/O bus. It answers at two addresses: an index port at a base address and a data port one address above it. The base is 0x2E or 0x4E, chosen by a strap input. After reset the block is locked. Writes to the index port are then treated as key bytes. Once the full four-byte key has been seen, the index port selects a configuration register and the data port reads or writes that register.

The register file has four parts:
- a global lock register;
- a device-select register that banks the per-device registers;
- a read-only two-byte chip identifier;
- a flash decode control register.

The device with number 7 holds a 16-bit flash interface base address, split across two registers. The decode control and flash base values are driven out to the rest of the chip. A write to the lock register returns the block to its locked state. Reads are combinational, so read data is valid in the same cycle as the read strobe.

Top module: `sio_cfg_gate`

## Requirements
- R1: After reset the block is locked, `flash_base` is 0x0000, `seg_cfg` is 0x02, the device select and the index are 0x00.
- R2: While locked, index-port writes of 0x87, 0x01, 0x55 and then a final byte unlock the block at the clock edge that accepts the final byte. The final byte must be 0x55 when `base_sel`=0 (base 0x2E) and 0xAA when `base_sel`=1 (base 0x4E).
- R3: A byte that does not match the expected key byte restarts detection. A byte of 0x87 always counts as the first key byte. For example, 0x87 0x87 0x01 0x55 0x55 unlocks with base 0x2E, while 0x87 0x01 0x00 0x55 0x55 does not.
- R4: While locked, data-port writes change no register and data-port reads return 0xFF. Index-port reads return 0xFF while locked and return the current index while unlocked.
- R5: While unlocked, index 0x20 reads 0x87 and index 0x21 reads 0x16. Writes to these two registers have no effect.
- R6: Index 0x07 is the device select and reads back what was written. Indices 0x64 and 0x65 reach the flash base high and low bytes only when the device select is 7. With any other device selected, writes there are ignored and reads there return 0x00.
- R7: Index 0x24 is the flash decode control register. Only bits 5..1 are writable, and bits 7, 6 and 0 read 0. The stored value drives `seg_cfg`.
- R8: A data-port write to index 0x02 with bit 1 set locks the block at that clock edge. A write there with bit 1 clear leaves the block unlocked.
- R9: Accesses to the base pair that `base_sel` does not select have no effect, and reads there return 0xFF.
- R10: `unlocked` is 1 exactly while the register file is accessible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_sel | input | 1 | Strap: 0 selects base 0x2E, 1 selects base 0x4E |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while `io_rd` is high |
| unlocked | output | 1 | Configuration space is open |
| flash_base | output | 16 | Flash interface base address (device 7, indices 0x64/0x65) |
| seg_cfg | output | 8 | Flash decode control register (index 0x24) |

## Verification
The assertions check four things on every cycle:
- unlocking happens only right after a correct final key byte at the selected index port;
- the lock write closes the block on the next edge;
- locked data reads return 0xFF;
- the flash base cannot move while locked.

Other behaviour can only be shown by the bench scenarios against its queue-based model. This covers:
- restart of key detection after wrong bytes and repeated 0x87;
- the key's dependence on the strap;
- read-only identifier bytes;
- device banking of the flash base;
- the writable mask of the decode register;
- immunity to the unselected port pair.

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate #(
  parameter int          AW        = 16,
  parameter logic [15:0] CHIP_ID   = 16'h8716,
  parameter logic [7:0]  FLASH_LDN = 8'h07,
  parameter logic [7:0]  SEG_RST   = 8'h02,
  parameter logic [7:0]  SEG_MASK  = 8'h3E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_sel,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic          unlocked,
  output logic [15:0]   flash_base,
  output logic [7:0]    seg_cfg
);
  localparam logic [AW-1:0] BASE_LO = AW'(16'h002E);
  localparam logic [AW-1:0] BASE_HI = AW'(16'h004E);
  localparam logic [7:0] K0 = 8'h87, K1 = 8'h01, K2 = 8'h55;

  logic [AW-1:0] base;
  logic          hit_idx, hit_dat;
  logic [1:0]    step;
  logic [7:0]    idx, ldn, key_byte, reg_val;
  logic          ldn_flash;

  assign base      = base_sel ? BASE_HI : BASE_LO;
  assign hit_idx   = io_addr == base;
  assign hit_dat   = io_addr == base + AW'(1);
  assign ldn_flash = ldn == FLASH_LDN;

  always_comb begin
    case (step)
      2'd0:    key_byte = K0;
      2'd1:    key_byte = K1;
      2'd2:    key_byte = K2;
      default: key_byte = base_sel ? 8'hAA : 8'h55;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked   <= 1'b0;
      step       <= 2'd0;
      idx        <= 8'h00;
      ldn        <= 8'h00;
      seg_cfg    <= SEG_RST;
      flash_base <= 16'h0000;
    end else if (io_wr && hit_idx) begin
      if (unlocked) idx <= io_wdata;
      else if (io_wdata == K0) step <= 2'd1;
      else if (step != 2'd0 && io_wdata == key_byte) begin
        if (step == 2'd3) begin
          unlocked <= 1'b1;
          step     <= 2'd0;
        end else step <= step + 2'd1;
      end else step <= 2'd0;
    end else if (io_wr && hit_dat && unlocked) begin
      case (idx)
        8'h02: if (io_wdata[1]) unlocked <= 1'b0;
        8'h07: ldn <= io_wdata;
        8'h24: seg_cfg <= io_wdata & SEG_MASK;
        8'h64: if (ldn_flash) flash_base[15:8] <= io_wdata;
        8'h65: if (ldn_flash) flash_base[7:0] <= io_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      8'h07:   reg_val = ldn;
      8'h20:   reg_val = CHIP_ID[15:8];
      8'h21:   reg_val = CHIP_ID[7:0];
      8'h24:   reg_val = seg_cfg;
      8'h64:   reg_val = ldn_flash ? flash_base[15:8] : 8'h00;
      8'h65:   reg_val = ldn_flash ? flash_base[7:0] : 8'h00;
      default: reg_val = 8'h00;
    endcase
  end

  assign io_rdata = !(io_rd && unlocked) ? 8'hFF :
                    hit_idx ? idx :
                    hit_dat ? reg_val : 8'hFF;
endmodule

// File: rtl/sio_cfg_gate_chk.sv
module sio_cfg_gate_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          base_sel,
  input logic [AW-1:0] io_addr,
  input logic          io_wr,
  input logic          io_rd,
  input logic [7:0]    io_wdata,
  input logic [7:0]    io_rdata,
  input logic          unlocked,
  input logic [15:0]   flash_base,
  input logic [7:0]    idx
);
  logic [AW-1:0] b;
  logic [7:0]    last_key;
  assign b        = base_sel ? AW'(16'h004E) : AW'(16'h002E);
  assign last_key = base_sel ? 8'hAA : 8'h55;

  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(io_wr && io_addr == b && io_wdata == last_key));

  p_lock_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_wr && io_addr == b + AW'(1) && idx == 8'h02 && io_wdata[1]) |=> !unlocked);

  p_locked_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_rd) |-> io_rdata == 8'hFF);

  p_base_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(flash_base));

  p_reset_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !unlocked);
endmodule

bind sio_cfg_gate sio_cfg_gate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
  .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .unlocked(unlocked), .flash_base(flash_base), .idx(idx)
);

// File: tb/sim_sio_cfg_gate.sv
`timescale 1ns/1ps
module sim_sio_cfg_gate;
  logic clk = 0, rst_n = 0, base_sel = 0, io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata, seg_cfg;
  logic unlocked;
  logic [15:0] flash_base;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sio_cfg_gate u0 (.clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .unlocked(unlocked), .flash_base(flash_base), .seg_cfg(seg_cfg));

  bit m_open = 0;
  int m_idx = 0, m_ldn = 0, m_seg = 'h02, m_fb = 0;
  byte unsigned hist[$];

  function automatic int mbase();
    return base_sel ? 'h4E : 'h2E;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_read(int a);
    if (!m_open) return 'hFF;
    if (a == mbase()) return m_idx;
    if (a != mbase() + 1) return 'hFF;
    case (m_idx)
      'h07: return m_ldn;
      'h20: return 'h87;
      'h21: return 'h16;
      'h24: return m_seg;
      'h64: return m_ldn == 7 ? m_fb >> 8 : 0;
      'h65: return m_ldn == 7 ? m_fb & 'hFF : 0;
      default: return 0;
    endcase
  endfunction

  task automatic model_write(int a, int d);
    if (a == mbase()) begin
      if (m_open) m_idx = d;
      else begin
        hist.push_back(byte'(d));
        if (hist.size() > 4) void'(hist.pop_front());
        if (hist.size() == 4 && hist[0] == 'h87 && hist[1] == 'h01 && hist[2] == 'h55 &&
            hist[3] == (base_sel ? 'hAA : 'h55)) begin
          m_open = 1;
          hist.delete();
        end
      end
    end else if (a == mbase() + 1 && m_open) begin
      if (m_idx == 'h02 && d[1]) m_open = 0;
      else if (m_idx == 'h07) m_ldn = d;
      else if (m_idx == 'h24) m_seg = d & 'h3E;
      else if (m_idx == 'h64 && m_ldn == 7) m_fb = (d << 8) | (m_fb & 'hFF);
      else if (m_idx == 'h65 && m_ldn == 7) m_fb = (m_fb & 'hFF00) | d;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1;
    @(posedge clk); #1;
    io_wr = 0;
    model_write(a, d);
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    io_addr = 16'(a); io_rd = 1;
    #1 check(req, io_rdata, exp_read(a));
    @(posedge clk); #1;
    io_rd = 0;
  endtask

  task automatic key(int last);
    wr(mbase(), 'h87); wr(mbase(), 'h01); wr(mbase(), 'h55); wr(mbase(), last);
  endtask

  task automatic reg_wr(int i, int d);
    wr(mbase(), i); wr(mbase() + 1, d);
  endtask

  task automatic reg_rd(int i, string req);
    wr(mbase(), i); rd(mbase() + 1, req);
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R10 unlocked", unlocked, m_open);
    check("R6 flash_base", flash_base, m_fb);
    check("R7 seg_cfg", seg_cfg, m_seg);
  end

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 unlocked", unlocked, 0);
    check("R1 flash_base", flash_base, 0);
    check("R1 seg_cfg", seg_cfg, 'h02);
    // R4 locked access
    rd('h2F, "R4 locked data read");
    rd('h2E, "R4 locked index read");
    wr('h2F, 'h33);
    // R2 wrong tail for base 0x2E
    key('hAA);
    check("R2 AA on 2E stays locked", unlocked, 0);
    key('h55);
    check("R2 unlock 2E", unlocked, 1);
    reg_rd('h07, "R1 ldn reset / R4 ignored write");
    rd('h2E, "R4 index readback");
    reg_rd('h20, "R5 id hi");
    reg_rd('h21, "R5 id lo");
    reg_wr('h20, 'h00);
    reg_rd('h20, "R5 id read-only");
    reg_wr('h24, 'hFF);
    reg_rd('h24, "R7 mask");
    check("R7 seg_cfg", seg_cfg, 'h3E);
    reg_wr('h07, 'h07);
    reg_wr('h64, 'h12);
    reg_wr('h65, 'h34);
    check("R6 flash base", flash_base, 'h1234);
    reg_wr('h07, 'h03);
    reg_wr('h64, 'h99);
    reg_rd('h64, "R6 other device reads 0");
    check("R6 other device write ignored", flash_base, 'h1234);
    reg_wr('h07, 'h07);
    reg_rd('h64, "R6 device 7 hi");
    reg_wr('h02, 'h00);
    check("R8 bit1 clear keeps open", unlocked, 1);
    reg_wr('h02, 'h02);
    check("R8 lock", unlocked, 0);
    rd('h2F, "R8 locked read FF");
    // R3 restart cases
    wr('h2E, 'h87); wr('h2E, 'h01); wr('h2E, 'h00); wr('h2E, 'h55); wr('h2E, 'h55);
    check("R3 wrong byte", unlocked, 0);
    wr('h2E, 'h87); wr('h2E, 'h87); wr('h2E, 'h01); wr('h2E, 'h55); wr('h2E, 'h55);
    check("R3 repeated 87", unlocked, 1);
    reg_wr('h02, 'h02);
    wr('h2E, 'h87); wr('h2E, 'h01); key('h55);
    check("R3 restart mid key", unlocked, 1);
    reg_wr('h02, 'h02);
    // R9 other base
    wr('h4E, 'h87); wr('h4E, 'h01); wr('h4E, 'h55); wr('h4E, 'hAA); wr('h4E, 'h55);
    check("R9 other base ignored", unlocked, 0);
    base_sel = 1;
    key('h55);
    check("R2 55 on 4E stays locked", unlocked, 0);
    key('hAA);
    check("R2 unlock 4E", unlocked, 1);
    rd('h2F, "R9 old data port FF");
    reg_wr('h02, 'h02);
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int a, d, pick;
      pick = $urandom_range(0, 9);
      a = (pick < 5) ? 'h4E : (pick < 8) ? 'h4F : (pick == 8 ? 'h2E : 'h2F);
      case ($urandom_range(0, 11))
        0: d = 'h87; 1: d = 'h01; 2: d = 'h55; 3: d = 'hAA;
        4: d = 'h07; 5: d = 'h24; 6: d = 'h64; 7: d = 'h65;
        8: d = 'h20; 9: d = 'h02; 10: d = 'h07;
        default: d = $urandom_range(0, 255);
      endcase
      if ($urandom_range(0, 3) == 0) rd(a, "R4 R6 R7 mixed read");
      else wr(a, d);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule